// File: doc/BRIEF.md
# Rewindable FIFO with Occupancy Flags

This block is a first-in first-out buffer of 9-bit words, 4096 deep by default, driven by active-low write and read strobes. Both strobes are brought into the system clock domain through a short synchroniser. Each falling edge that is detected counts as one access: a write stores the word on `din`, and a read presents the oldest unread word on `dout`. Three active-low flags report how full the buffer is: empty, more than half full, and full. Each flag changes on the strobe edge that the flag rules name, so a system can pace its accesses from the flags alone.

An active-low rewind strobe moves the read pointer back to physical location zero and leaves the write pointer where it is. The block that has been written since reset can then be read again, as many times as needed, as long as the writes do not wrap the memory. The read data is driven only while an accepted read is in progress. At all other times `dout_oe` is low, which marks the bus as high-impedance, and `dout` reads zero. If the read strobe is already low while the buffer is empty, the first word written afterwards flows straight through to the output. Write data must be held stable on `din` from the falling edge of the write strobe until the strobe rises again.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both pointers and the occupancy, and after that edge `empty_n`=0, `half_n`=1, `full_n`=1 and `dout_oe`=0.
- R2: Words are read out in the order they were written, and this holds across the wrap of the pointers through the whole memory depth.
- R3: With n unread words and depth D, once the strobes involved are back high the flags are: n=0 gives `empty_n`=0 with the other two flags high; 1≤n≤D/2 gives all three flags high; D/2<n<D gives only `half_n`=0; n=D gives `half_n`=0 and `full_n`=0.
- R4: A falling edge of the write strobe while `full_n` is low stores nothing and changes no pointer.
- R5: A falling edge of the read strobe while `empty_n` is low takes no word and leaves `dout_oe` low.
- R6: `full_n` and `half_n` go low on the write falling edge that takes the occupancy to their threshold. They go high again only on the rising edge of the read strobe that ends the read which freed the space.
- R7: `empty_n` goes low on the read falling edge that takes the last word, and goes high on the rising edge of the write strobe that ends the next accepted write.
- R8: A falling edge of the rewind strobe, with both access strobes high and no access outstanding, sets the read pointer to zero and the occupancy to the number of writes since reset (at most D). All three flags are recomputed on that edge.
- R9: A rewind falling edge while the read or write strobe is low has no effect on the pointers or the flags.
- R10: If the read strobe falls while the buffer is empty and stays low, the first word written after that appears on `dout` with `dout_oe`=1 when that write strobe rises, and `empty_n` stays low. Later writes are not shown until the read strobe has risen and fallen again.
- R11: `dout_oe` is high from the cycle in which a read is accepted until the rising edge of the read strobe, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind strobe |
| din | input | 9 | Write data, held stable while `wr_n` is low |
| dout | output | 9 | Read data; zero whenever `dout_oe` is low |
| dout_oe | output | 1 | High while `dout` is driven; low means high-impedance |
| empty_n | output | 1 | Active-low empty flag |
| half_n | output | 1 | Active-low flag for more than half full |
| full_n | output | 1 | Active-low full flag |

## Verification
The hardest situation to reach from the ports is a rewind taken at the full boundary. There the write pointer has advanced by exactly the whole depth, so the recomputed occupancy must come out as full rather than zero, and the whole block must then be replayed across the half-full threshold. The bench gets there with directed stimulus: it fills the buffer exactly to capacity, tries one extra write that must be refused, reads a word, rewinds, and reads all 4096 words back. After that it rewinds again and then tries a rewind with the read strobe held low. Before these directed steps, a seeded random mix of reads and writes, including reads on an empty buffer, exercises ordering and the flags at low fill levels. A directed flow-through sequence follows the random mix.

// File: rtl/rfifo_pkg.sv
// Shared types for the rewindable FIFO.
// Assumes: strobes are active-low and idle high.
package rfifo_pkg;
    // Level and edges of one active-low strobe after synchronisation
    typedef struct packed {
        logic lvl;   // synchronised level, 1 = inactive
        logic fall;  // strobe became active this cycle
        logic rise;  // strobe became inactive this cycle
    } strobe_t;
endpackage

// File: rtl/rfifo_strobe_sync.sv
// Synchronises one active-low strobe into the clock domain and reports its
// level and edges. Assumes: the strobe idles high; reset forces the chain to
// the idle level so that no edge appears when reset is released.
module rfifo_strobe_sync
    import rfifo_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    strobe_n,
    output strobe_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the strobe
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= strobe_n;
            end
        end else begin : g_chain
            // Multi-stage shift chain for metastability settling
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], strobe_n};
            end
        end
    endgenerate

    // Delayed copy of the settled level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    // Edge decode
    always_comb begin
        ev.lvl  = chain[STAGES-1];
        ev.fall = prev & ~chain[STAGES-1];
        ev.rise = ~prev & chain[STAGES-1];
    end
endmodule

// File: rtl/rfifo_store.sv
// Word storage with one synchronous write port and one combinational read
// port. Assumes: addresses are in range; contents are not reset.
module rfifo_store #(
    parameter int DW    = 9,
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store a word on an accepted write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the word at the read pointer
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/rfifo_ctrl.sv
// Pointer, occupancy and flag control for the rewindable FIFO.
// Decides which strobe edges are accepted, handles flow-through from empty
// and rewinds the read pointer. Assumes: DEPTH is a power of two, and rewinds
// are used only while the writes since reset number no more than DEPTH.
module rfifo_ctrl
    import rfifo_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       wr,
    input  strobe_t       rd,
    input  strobe_t       rt,
    output logic          wr_acc,
    output logic [AW-1:0] wr_addr,
    output logic          take,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] occ,
    output logic          empty_q,
    output logic          half_q,
    output logic          full_q,
    output logic          oe
);
    logic [CW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] occ_nxt;
    logic [CW-1:0] rewind_occ;
    logic          wr_pend, rd_pend, rd_wait;
    logic          rd_acc, flow, rewind;
    logic          upd_hi, upd_lo;

    // Accept decisions for this cycle
    always_comb begin
        wr_acc = wr.fall & ~full_q;
        rd_acc = rd.fall & ~empty_q;
        flow   = wr.rise & wr_pend & rd_wait & ~rd.lvl;
        take   = rd_acc | flow;
        rewind = rt.fall & wr.lvl & rd.lvl & ~wr_pend & ~rd_pend;
    end

    // Occupancy after a rewind: writes since reset, capped at the depth
    always_comb begin
        if (wp[AW]) rewind_occ = CW'(DEPTH);
        else        rewind_occ = {1'b0, wp[AW-1:0]};
    end

    // Next occupancy
    always_comb begin
        if (rewind) occ_nxt = rewind_occ;
        else        occ_nxt = occ + CW'(wr_acc) - CW'(take);
    end

    // Flag update events
    always_comb begin
        upd_hi = wr_acc | (rd.rise & rd_pend) | rewind;
        upd_lo = take | (wr.rise & wr_pend) | rewind;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (wr_acc) wp <= wp + 1'b1;
            if (rewind)    rp <= '0;
            else if (take) rp <= rp + 1'b1;
            occ <= occ_nxt;
        end
    end

    // Flags, each updated only on its own edge events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            half_q  <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            if (upd_hi) begin
                full_q <= (occ_nxt == CW'(DEPTH));
                half_q <= (occ_nxt > CW'(HALF));
            end
            if (upd_lo) empty_q <= (occ_nxt == '0);
        end
    end

    // Outstanding access tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend <= 1'b0;
            rd_pend <= 1'b0;
            rd_wait <= 1'b0;
        end else begin
            if (wr_acc)       wr_pend <= 1'b1;
            else if (wr.rise) wr_pend <= 1'b0;
            if (take)         rd_pend <= 1'b1;
            else if (rd.rise) rd_pend <= 1'b0;
            if (rd.fall && empty_q)  rd_wait <= 1'b1;
            else if (rd.rise || flow) rd_wait <= 1'b0;
        end
    end

    // Port assignments
    always_comb begin
        wr_addr = wp[AW-1:0];
        rd_addr = rp;
        oe      = rd_pend;
    end
endmodule

// File: rtl/rewind_fifo.sv
// Top of the rewindable FIFO: strobe synchronisers, control, storage and the
// output data register. Assumes: din is stable while wr_n is low; strobes
// stay at each level for at least three clock cycles.
module rewind_fifo
    import rfifo_pkg::*;
#(
    parameter int DW          = 9,
    parameter int DEPTH       = 4096,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          rt_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          empty_n,
    output logic          half_n,
    output logic          full_n
);
    strobe_t       wr_ev, rd_ev, rt_ev;
    logic          wr_acc, take;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] occ;
    logic          empty_q, half_q, full_q, oe;
    logic [DW-1:0] rdata;
    logic [DW-1:0] dout_q;

    rfifo_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .ev(wr_ev));
    rfifo_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .ev(rd_ev));
    rfifo_strobe_sync #(.STAGES(SYNC_STAGES)) u_rt_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(rt_n), .ev(rt_ev));

    rfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_ev), .rd(rd_ev), .rt(rt_ev),
        .wr_acc(wr_acc), .wr_addr(wr_addr),
        .take(take), .rd_addr(rd_addr),
        .occ(occ),
        .empty_q(empty_q), .half_q(half_q), .full_q(full_q),
        .oe(oe));

    rfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(wr_acc), .waddr(wr_addr), .wdata(din),
        .raddr(rd_addr), .rdata(rdata));

    // Capture the word being read
    always_ff @(posedge clk) begin
        if (!rst_n)    dout_q <= '0;
        else if (take) dout_q <= rdata;
    end

    // Output drive and active-low flags
    always_comb begin
        dout    = oe ? dout_q : '0;
        dout_oe = oe;
        empty_n = ~empty_q;
        half_n  = ~half_q;
        full_n  = ~full_q;
    end
endmodule

// File: rtl/rewind_fifo_chk.sv
// Property checker for rewind_fifo, attached by bind.
// Assumes: occ is the internal occupancy count of the top module.
module rewind_fifo_chk #(
    parameter int DEPTH = 4096,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          empty_n,
    input logic          half_n,
    input logic          full_n,
    input logic          dout_oe,
    input logic [CW-1:0] occ
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!empty_n && half_n && full_n && !dout_oe));

    assert_full_implies_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);

    assert_empty_full_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |=> occ <= $past(occ));

    assert_full_at_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n) |-> occ == CW'(DEPTH));

    assert_empty_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_n) |-> occ != '0);
endmodule

bind rewind_fifo rewind_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .empty_n(empty_n), .half_n(half_n),
    .full_n(full_n), .dout_oe(dout_oe), .occ(occ));

// File: tb/sim_rewind_fifo.sv
module sim_rewind_fifo;
    localparam int DW = 9;
    localparam int D  = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe, empty_n, half_n, full_n;

    int nchk = 0, nerr = 0;

    // Bench model state
    logic [DW-1:0] m_mem [D];
    int m_wp = 0, m_rp = 0, m_cnt = 0, m_wtot = 0;
    bit m_empty = 1, m_half = 0, m_full = 0;
    bit m_wpend = 0, m_rpend = 0, m_rwait = 0;
    logic [DW-1:0] m_dout = '0;

    always #2 clk = ~clk;

    rewind_fifo #(.DW(DW), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .half_n(half_n), .full_n(full_n));

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_flags();
        return {29'd0, !m_empty, !m_half, !m_full};
    endfunction

    function automatic bit half_of(input int n);
        return n > D / 2;
    endfunction

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " flags R3/R6/R7"}, {29'd0, empty_n, half_n, full_n}, exp_flags());
        chk({tag, " oe R11"}, int'(dout_oe), int'(m_rpend));
        if (m_rpend) chk({tag, " data R2"}, int'(dout), int'(m_dout));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_wp = 0; m_rp = 0; m_cnt = 0; m_wtot = 0;
        m_empty = 1; m_half = 0; m_full = 0;
        m_wpend = 0; m_rpend = 0; m_rwait = 0;
        chk("R1 reset flags", {29'd0, empty_n, half_n, full_n}, 3'b011);
        chk("R1 reset oe", int'(dout_oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic take_word();
        m_dout = m_mem[m_rp % D];
        m_rp++; m_cnt--;
        m_empty = (m_cnt == 0);
        m_rpend = 1;
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        din = d; wr_n = 1'b0;
        settle();
        if (!m_full) begin
            m_mem[m_wp % D] = d;
            m_wp++; m_wtot++; m_cnt++;
            m_full = (m_cnt == D); m_half = half_of(m_cnt);
            m_wpend = 1;
        end
        chk_state("write-low");
        wr_n = 1'b1;
        settle();
        if (m_wpend) begin
            m_wpend = 0;
            if (m_rwait && !rd_n) begin
                m_rwait = 0;
                take_word();
            end else begin
                m_empty = (m_cnt == 0);
            end
        end
        chk_state("write-high");
    endtask

    task automatic read_low();
        rd_n = 1'b0;
        settle();
        if (!m_empty) take_word();
        else m_rwait = 1;
        chk_state("read-low");
    endtask

    task automatic read_high();
        rd_n = 1'b1;
        settle();
        if (m_rpend) begin
            m_full = (m_cnt == D); m_half = half_of(m_cnt);
            m_rpend = 0;
        end
        m_rwait = 0;
        chk_state("read-high");
    endtask

    task automatic rewind();
        rt_n = 1'b0;
        settle();
        if (rd_n && wr_n && !m_rpend && !m_wpend) begin
            m_rp = 0;
            m_cnt = (m_wtot >= D) ? D : m_wtot;
            m_empty = (m_cnt == 0); m_full = (m_cnt == D); m_half = half_of(m_cnt);
        end
        chk_state("rewind R8/R9");
        rt_n = 1'b1;
        settle();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2718);
        do_reset();

        // Random mix at low fill: ordering, empty reads ignored (R2, R5)
        for (int i = 0; i < 300; i++) begin
            int sel;
            sel = $urandom % 3;
            if (sel != 2) write_word(DW'($urandom));
            else begin
                bit was_empty;
                was_empty = m_empty;
                read_low();
                if (was_empty) chk("R5 empty read ignored oe", int'(dout_oe), 0);
                read_high();
            end
        end
        while (m_cnt > 0) begin read_low(); read_high(); end
        read_low();
        chk("R5 read on empty oe", int'(dout_oe), 0);
        chk("R5 read on empty flag", int'(empty_n), 0);
        read_high();

        // Flow-through from empty (R10)
        read_low();
        write_word(9'h1A5);
        chk("R10 flow word", int'(dout), 9'h1A5);
        chk("R10 flow oe", int'(dout_oe), 1);
        chk("R10 empty stays", int'(empty_n), 0);
        write_word(9'h0C3);
        chk("R10 later word hidden", int'(dout), 9'h1A5);
        read_high();
        read_low();
        chk("R10 second word after toggle", int'(dout), 9'h0C3);
        read_high();

        // Fill to the depth, thresholds (R3, R6)
        do_reset();
        for (int i = 0; i < D; i++) begin
            write_word(DW'((i * 37 + 5) % 512));
            if (i == D / 2 - 1) chk("R3 half clear at D/2", int'(half_n), 1);
            if (i == D / 2)     chk("R6 half set at D/2+1", int'(half_n), 0);
        end
        chk("R6 full at depth", int'(full_n), 0);
        write_word(9'h1FF);
        chk("R4 extra write refused, still full", int'(full_n), 0);

        // Full released only at read rise (R6)
        read_low();
        chk("R6 full held during read", int'(full_n), 0);
        read_high();
        chk("R6 full released on read rise", int'(full_n), 1);

        // Rewind with write pointer at exactly the depth (R8)
        rewind();
        chk("R8 rewind back to full", int'(full_n), 0);
        for (int i = 0; i < D; i++) begin
            read_low();
            chk("R8 replay data R4", int'(dout), (i * 37 + 5) % 512);
            read_high();
        end
        chk("R7 empty after replay", int'(empty_n), 0);

        // Second rewind, then a rewind blocked by an active read (R9)
        rewind();
        chk("R8 second rewind flags", {29'd0, empty_n, half_n, full_n}, 3'b100);
        for (int i = 0; i < 3; i++) begin read_low(); read_high(); end
        read_low();
        chk("R9 word before blocked rewind", int'(dout), (3 * 37 + 5) % 512);
        rewind();
        read_high();
        read_low();
        chk("R9 read continues after blocked rewind", int'(dout), (4 * 37 + 5) % 512);
        read_high();

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule